// File: doc/BRIEF.md
# Per-Voice Configuration Register Interface

A write-only host register port for a sixteen-voice, time-multiplexed synthesis engine. The host presents an 8-bit data byte, one address-select bit and a write strobe. A byte written to address 0 is a command: it picks how the next configuration byte is to be stored, sets or clears a key-sync flag, and drives a group of test controls. A byte written to address 1 is a configuration byte: an algorithm number in its upper five bits and a feedback level in its lower three bits.

Configuration bytes live in a recirculating loop with one entry per voice. The loop advances one position for each voice slot of the engine. An entry can be replaced only while it leaves the head of the loop. The replacement goes either into every entry as each one passes (broadcast) or into the one entry whose voice number equals the selected target (single-voice). The entry at the head of the loop belongs to the voice now being processed, and its two fields are presented to the engine together with that voice number.

Top module: `voice_cfg_regs`

## Requirements
- R1: After reset, cur_voice is 0, key_sync, phase_clr, scale_bypass, latch_bypass, cnt_reset and low_phase are 0, and every voice's stored byte reads 0.
- R2: For the voice shown on cur_voice, cur_alg is bits 7:3 of its stored byte and cur_fb is bits 2:0.
- R3: After an address-0 byte with bit 7 = 0, bit 4 = 1 and bit 2 = 0 (broadcast), a later address-1 byte is stored into all sixteen voices within two loop passes, whatever the other command bits are.
- R4: After an address-0 byte with bit 7 = 0 and bit 4 = 0 (single-voice), a later address-1 byte is stored only into the voice numbered by bits 3:0, and every other voice keeps its byte.
- R5: After an address-0 byte that is neither broadcast nor single-voice (bit 7 = 1, or bit 4 = 1 with bit 2 = 1), address-1 bytes change no stored byte.
- R6: The voice number advances by one, from 15 back to 0, in each cycle where slot_en is 1, and holds in each cycle where it is 0. With no store pending, every stored byte comes back unchanged after each pass.
- R7: An address-1 write that arrives in the very slot in which the target voice leaves the loop does not land on that pass. The next time the voice is shown, it still carries its old byte, and the time after that it carries the new one.
- R8: In the cycle after each address-0 write, phase_clr, scale_bypass and latch_bypass all equal bit 7 of that byte. They hold through address-1 writes.
- R9: In the cycle after each address-0 write, cnt_reset equals bit 7 AND bit 0, and low_phase equals bit 7 AND bit 1.
- R10: On an address-0 write, key_sync becomes 0 if bit 6 is 1. Otherwise it becomes 1 if bit 5 is 1. Otherwise it holds. When bits 6 and 5 are both 1, clearing wins.
- R11: The target voice number changes only on address-0 writes. An address-1 byte, whatever its low bits, does not move later single-voice stores to another voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | One pulse per voice slot; advances the loop |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = command byte, 1 = configuration byte |
| wr_data | input | 8 | Host data byte |
| cur_voice | output | 4 | Voice now at the loop head |
| cur_alg | output | 5 | Algorithm number of that voice |
| cur_fb | output | 3 | Feedback level of that voice |
| key_sync | output | 1 | Key-sync flag |
| phase_clr | output | 1 | Test reset: clear phase accumulators |
| scale_bypass | output | 1 | Test reset: output scaling disabled |
| latch_bypass | output | 1 | Test reset: output latch bypassed |
| cnt_reset | output | 1 | Test: reset voice/operator sequencing counters |
| low_phase | output | 1 | Test: use low-order phase bits for the waveform |

## Verification
The collision that matters is a host address-1 write that lands in the same clock edge as the loop exit of the voice it targets. The bench watches cur_voice and drives the write in exactly the cycle the target voice sits at the head. The scoreboard then expects the old byte on that voice's next appearance and the new byte on the one after. A second same-cycle case sets and clears key-sync in one command byte, and the bench expects the clear to win.

// File: rtl/voice_cfg_pkg.sv
package voice_cfg_pkg;
  localparam int BUS_W       = 8;
  localparam int TEST_BIT    = 7;
  localparam int KS_CLR_BIT  = 6;
  localparam int KS_SET_BIT  = 5;
  localparam int MODE_BIT    = 4;
  localparam int ALLGATE_BIT = 2;
  localparam int LOPH_BIT    = 1;
  localparam int CRST_BIT    = 0;

  typedef enum logic [1:0] {
    WM_NONE = 2'd0,
    WM_ALL  = 2'd1,
    WM_ONE  = 2'd2
  } wmode_e;

  typedef struct packed {
    logic             sel;
    logic [BUS_W-1:0] val;
  } hold_t;
endpackage

// File: rtl/cfg_hold_latch.sv
module cfg_hold_latch
  import voice_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output hold_t            hold
);
  // Every host write lands here, address bit included.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (wr_en) begin
      hold.sel <= wr_addr;
      hold.val <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import voice_cfg_pkg::*;
#(
  parameter int VOICE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  output wmode_e             mode,
  output logic [VOICE_W-1:0] tgt_voice,
  output logic               key_sync,
  output logic               phase_clr,
  output logic               scale_bypass,
  output logic               latch_bypass,
  output logic               cnt_reset,
  output logic               low_phase
);
  localparam int TGT_W = VOICE_W + 1;

  logic [TGT_W-1:0] tgt_q;
  logic             cmd_wr;

  assign cmd_wr = wr_en && !wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q        <= '0;
      key_sync     <= 1'b0;
      phase_clr    <= 1'b0;
      scale_bypass <= 1'b0;
      latch_bypass <= 1'b0;
      cnt_reset    <= 1'b0;
      low_phase    <= 1'b0;
    end else if (cmd_wr) begin
      tgt_q        <= wr_data[TGT_W-1:0];
      phase_clr    <= wr_data[TEST_BIT];
      scale_bypass <= wr_data[TEST_BIT];
      latch_bypass <= wr_data[TEST_BIT];
      cnt_reset    <= wr_data[TEST_BIT] & wr_data[CRST_BIT];
      low_phase    <= wr_data[TEST_BIT] & wr_data[LOPH_BIT];
      if (wr_data[KS_CLR_BIT])
        key_sync <= 1'b0;
      else if (wr_data[KS_SET_BIT])
        key_sync <= 1'b1;
    end
  end

  // Store mode follows from the held command: test bit and target register.
  always_comb begin
    if (phase_clr)
      mode = WM_NONE;
    else if (!tgt_q[MODE_BIT])
      mode = WM_ONE;
    else if (!tgt_q[ALLGATE_BIT])
      mode = WM_ALL;
    else
      mode = WM_NONE;
  end

  assign tgt_voice = tgt_q[VOICE_W-1:0];
endmodule

// File: rtl/voice_match.sv
module voice_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  logic [W-1:0] same;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign same[i] = ~(a[i] ^ b[i]);
    end
  endgenerate

  assign eq = &same;
endmodule

// File: rtl/voice_loop.sv
module voice_loop #(
  parameter int NUM_VOICES = 16,
  parameter int DATA_W     = 8,
  parameter int VOICE_W    = $clog2(NUM_VOICES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               wr_all,
  input  logic               wr_one,
  input  logic [VOICE_W-1:0] tgt_voice,
  input  logic [DATA_W-1:0]  din,
  output logic [VOICE_W-1:0] voice,
  output logic [DATA_W-1:0]  head
);
  localparam logic [VOICE_W-1:0] LAST_VOICE = VOICE_W'(NUM_VOICES - 1);

  logic [DATA_W-1:0] ring [NUM_VOICES];
  logic              hit;
  logic              take;
  logic [DATA_W-1:0] tail_in;

  voice_match #(.W(VOICE_W)) u_match (
    .a  (voice),
    .b  (tgt_voice),
    .eq (hit)
  );

  assign take    = wr_all || (wr_one && hit);
  assign tail_in = take ? din : ring[0];

  // ring[k] holds the byte of voice (voice + k) mod NUM_VOICES.
  always_ff @(posedge clk) begin
    if (rst) begin
      voice <= '0;
      for (int k = 0; k < NUM_VOICES; k++) ring[k] <= '0;
    end else if (step) begin
      voice <= (voice == LAST_VOICE) ? '0 : voice + 1'b1;
      for (int k = 0; k < NUM_VOICES - 1; k++) ring[k] <= ring[k+1];
      ring[NUM_VOICES-1] <= tail_in;
    end
  end

  assign head = ring[0];
endmodule

// File: rtl/voice_cfg_regs.sv
module voice_cfg_regs
  import voice_cfg_pkg::*;
#(
  parameter int NUM_VOICES = 16,
  parameter int ALG_W      = 5,
  parameter int FB_W       = 3,
  parameter int VOICE_W    = $clog2(NUM_VOICES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_en,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [VOICE_W-1:0] cur_voice,
  output logic [ALG_W-1:0]   cur_alg,
  output logic [FB_W-1:0]    cur_fb,
  output logic               key_sync,
  output logic               phase_clr,
  output logic               scale_bypass,
  output logic               latch_bypass,
  output logic               cnt_reset,
  output logic               low_phase
);
  localparam int DATA_W = ALG_W + FB_W;

  hold_t              hold;
  wmode_e             mode;
  logic [VOICE_W-1:0] tgt_voice;
  logic               cfg_ready;
  logic [DATA_W-1:0]  head;

  cfg_hold_latch u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hold    (hold)
  );

  cfg_cmd_decode #(.VOICE_W(VOICE_W)) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .mode         (mode),
    .tgt_voice    (tgt_voice),
    .key_sync     (key_sync),
    .phase_clr    (phase_clr),
    .scale_bypass (scale_bypass),
    .latch_bypass (latch_bypass),
    .cnt_reset    (cnt_reset),
    .low_phase    (low_phase)
  );

  // A store is armed while the holding latch carries a configuration byte.
  assign cfg_ready = hold.sel;

  voice_loop #(
    .NUM_VOICES (NUM_VOICES),
    .DATA_W     (DATA_W),
    .VOICE_W    (VOICE_W)
  ) u_loop (
    .clk       (clk),
    .rst       (rst),
    .step      (slot_en),
    .wr_all    (cfg_ready && (mode == WM_ALL)),
    .wr_one    (cfg_ready && (mode == WM_ONE)),
    .tgt_voice (tgt_voice),
    .din       (hold.val[DATA_W-1:0]),
    .voice     (cur_voice),
    .head      (head)
  );

  assign cur_alg = head[DATA_W-1:FB_W];
  assign cur_fb  = head[FB_W-1:0];
endmodule

// File: rtl/voice_cfg_regs_chk.sv
module voice_cfg_regs_chk #(
  parameter int VOICE_W = 4,
  parameter int ALG_W   = 5,
  parameter int FB_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               slot_en,
  input logic               wr_en,
  input logic               wr_addr,
  input logic [7:0]         wr_data,
  input logic [VOICE_W-1:0] cur_voice,
  input logic [ALG_W-1:0]   cur_alg,
  input logic [FB_W-1:0]    cur_fb,
  input logic               key_sync,
  input logic               phase_clr,
  input logic               scale_bypass,
  input logic               latch_bypass,
  input logic               cnt_reset,
  input logic               low_phase
);
  assert_voice_step_R6: assert property (@(posedge clk) disable iff (rst)
    slot_en |=> (cur_voice == $past(cur_voice) + 1'b1));

  assert_voice_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> ($stable(cur_voice) && $stable(cur_alg) && $stable(cur_fb)));

  assert_test_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (phase_clr == $past(wr_data[7]) &&
                             scale_bypass == $past(wr_data[7]) &&
                             latch_bypass == $past(wr_data[7])));

  assert_test_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !wr_addr) |=> ($stable(phase_clr) && $stable(cnt_reset) &&
                              $stable(low_phase) && $stable(key_sync)));

  assert_sub_tests_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (cnt_reset == ($past(wr_data[7]) & $past(wr_data[0])) &&
                             low_phase == ($past(wr_data[7]) & $past(wr_data[1]))));

  assert_ks_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[6]) |=> !key_sync);

  assert_ks_set_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && !wr_data[6] && wr_data[5]) |=> key_sync);
endmodule

bind voice_cfg_regs voice_cfg_regs_chk #(
  .VOICE_W (VOICE_W),
  .ALG_W   (ALG_W),
  .FB_W    (FB_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_en      (slot_en),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .cur_voice    (cur_voice),
  .cur_alg      (cur_alg),
  .cur_fb       (cur_fb),
  .key_sync     (key_sync),
  .phase_clr    (phase_clr),
  .scale_bypass (scale_bypass),
  .latch_bypass (latch_bypass),
  .cnt_reset    (cnt_reset),
  .low_phase    (low_phase)
);

// File: tb/voice_cfg_regs_test.sv
`timescale 1ns/1ps
module voice_cfg_regs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] cur_voice;
  logic [4:0] cur_alg;
  logic [2:0] cur_fb;
  logic       key_sync, phase_clr, scale_bypass, latch_bypass, cnt_reset, low_phase;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] model [16];
  int         q_voice [$];
  logic [7:0] q_byte [$];
  string      q_tag [$];

  always #5 clk = ~clk;

  voice_cfg_regs uut (
    .clk(clk), .rst(rst), .slot_en(slot_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cur_voice(cur_voice), .cur_alg(cur_alg), .cur_fb(cur_fb),
    .key_sync(key_sync), .phase_clr(phase_clr), .scale_bypass(scale_bypass),
    .latch_bypass(latch_bypass), .cnt_reset(cnt_reset), .low_phase(low_phase)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item once its voice reaches the loop head.
  always @(negedge clk) begin
    if (!rst && q_voice.size() > 0 && int'(cur_voice) == q_voice[0]) begin
      chk({q_tag[0], " alg"}, int'(cur_alg), int'(q_byte[0][7:3]));
      chk({q_tag[0], " fb"},  int'(cur_fb),  int'(q_byte[0][2:0]));
      void'(q_voice.pop_front());
      void'(q_byte.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic push(string tag, int v, logic [7:0] b);
    q_voice.push_back(v);
    q_byte.push_back(b);
    q_tag.push_back(tag);
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < 16; v++) push(tag, v, model[v]);
    while (q_voice.size() > 0) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] v0;
    for (int v = 0; v < 16; v++) model[v] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 voice", int'(cur_voice), 0);
    chk("R1 key_sync", int'(key_sync), 0);
    chk("R1 flags", int'({phase_clr, scale_bypass, latch_bypass, cnt_reset, low_phase}), 0);
    slot_en = 1'b1;
    sweep("R1 store");

    // R3 broadcast, then R2 field split
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h6B);
    idle(40);
    for (int v = 0; v < 16; v++) model[v] = 8'h6B;
    sweep("R3 broadcast");
    chk("R2 alg", int'(cur_alg), 13);
    chk("R2 fb", int'(cur_fb), 3);

    // R4 single voice
    wr(1'b0, 8'h05);
    wr(1'b1, 8'hA3);
    idle(40);
    model[5] = 8'hA3;
    sweep("R4 single");

    // R11 target unchanged by address-1 bytes
    wr(1'b1, 8'h4C);
    idle(40);
    model[5] = 8'h4C;
    sweep("R11 target");

    // R5 non-store commands
    wr(1'b0, 8'h14);
    wr(1'b1, 8'hFF);
    idle(40);
    sweep("R5 gated");
    wr(1'b0, 8'h90);
    @(negedge clk);
    chk("R8 phase_clr", int'(phase_clr), 1);
    chk("R8 scale_bypass", int'(scale_bypass), 1);
    chk("R8 latch_bypass", int'(latch_bypass), 1);
    chk("R9 cnt_reset 90", int'(cnt_reset), 0);
    wr(1'b1, 8'h11);
    idle(40);
    chk("R8 hold over addr1", int'(phase_clr), 1);
    sweep("R5 test gated");

    // R9 sub-tests
    wr(1'b0, 8'h81);
    chk("R9 cnt_reset 81", int'(cnt_reset), 1);
    chk("R9 low_phase 81", int'(low_phase), 0);
    wr(1'b0, 8'h82);
    chk("R9 cnt_reset 82", int'(cnt_reset), 0);
    chk("R9 low_phase 82", int'(low_phase), 1);
    wr(1'b0, 8'h03);
    chk("R9 no test bit", int'({cnt_reset, low_phase}), 0);
    chk("R8 cleared", int'({phase_clr, scale_bypass, latch_bypass}), 0);

    // R10 key sync
    wr(1'b0, 8'h20);
    chk("R10 set", int'(key_sync), 1);
    wr(1'b0, 8'h00);
    chk("R10 hold", int'(key_sync), 1);
    wr(1'b0, 8'h60);
    chk("R10 clear wins", int'(key_sync), 0);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h40);
    chk("R10 clear", int'(key_sync), 0);

    // R6 slot gating
    @(negedge clk);
    slot_en = 1'b0;
    v0 = cur_voice;
    idle(6);
    chk("R6 voice held", int'(cur_voice), int'(v0));
    chk("R6 byte held", int'({cur_alg, cur_fb}), int'(model[v0]));
    slot_en = 1'b1;
    @(negedge clk);
    chk("R6 voice step", int'(cur_voice), int'(v0 + 4'd1));
    sweep("R6 recirculate");

    // R7 write in the exit slot of its target
    wr(1'b0, 8'h09);
    while (cur_voice != 4'd9) @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'hF5;
    @(negedge clk);
    wr_en = 1'b0;
    push("R7 first pass old", 9, model[9]);
    push("R7 second pass new", 9, 8'hF5);
    while (q_voice.size() > 0) @(negedge clk);
    model[9] = 8'hF5;

    // R3 broadcast with other don't-care bits set
    wr(1'b0, 8'h7B);
    chk("R10 both bits", int'(key_sync), 0);
    wr(1'b1, 8'h2E);
    idle(40);
    for (int v = 0; v < 16; v++) model[v] = 8'h2E;
    sweep("R3 broadcast dc");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule